// File: doc/BRIEF.md
# Threshold-Sweep CDF Hit Accumulator

This block runs the digital side of an equivalent-time voltage measurement. The measured waveform repeats, and for each time slice the block walks a threshold code across a programmed window. At every threshold it gathers a programmed number of one-bit comparator decisions. A trial counter tallies every decision that arrives. A hit counter tallies the decisions that read high. When a threshold point has collected its trials, the block emits a one-cycle result that holds the code, the slice number, the hit count and the trial count. The hit-to-trial ratio is one sample of the cumulative distribution of the signal voltage at that slice.

After the last code of a slice, the block holds in a waiting state until it receives a command to start the next slice. It then repeats the threshold walk with the slice number incremented. A calibration run ties the comparator to its offset reference through the `cal_sel` output and measures a single point without any walk. The threshold DAC, the comparator, the timing generator and the conversion of the distribution to a density or a mean are all outside this block.

Both counters are `CNT_W` bits wide, 20 by default. At that width a point can average up to 1,048,575 trials, which covers one million.

Top module: `cdf_sweep_accum`

## Requirements
- R1: After reset, `busy`, `slice_done`, `result_valid` and `cal_sel` are all 0.
- R2: When `start` is seen while idle, the block latches the window (`thr_start`, `thr_stop`, `thr_step`), the trial target and `cal_mode`. From the next cycle, `busy` is 1, `thr_code` equals `thr_start`, `slice_idx` is 0 and both counters are zero.
- R3: Each cycle with `sample_strobe`=1 adds one trial. It adds one hit only when `comp_bit`=1. A cycle with `sample_strobe`=0 changes neither counter, whatever `comp_bit` is.
- R4: A point completes on the strobe that brings the trial count to the target. A target of 0 counts as 1. In the following cycle, `result_valid` is 1 for exactly that cycle, and it carries `res_thr` (the code of the point), `res_slice`, `res_hits` and `res_trials` (equal to the target). Both counters clear in the same cycle.
- R5: After each point the code advances by `thr_step`. The point just finished was the last one of the slice if code+step (computed without wrap) is greater than `thr_stop`, or if `thr_step` is 0. In that case `slice_done` rises and stays at 1, and strobes have no effect while it is 1.
- R6: `next_slice` while `slice_done`=1 increments `slice_idx`, reloads `thr_code` with the latched start and resumes the walk.
- R7: `start` while `busy`=1 is ignored. The code, the slice number and the counts all continue unchanged.
- R8: `abort` in any state makes `busy` 0 from the next cycle. No result is emitted for the interrupted point, and the next run starts with clear counters.
- R9: In a calibration run, `cal_sel` is 1 and `slice_done` stays 0. The block measures one point at the latched start code with slice 0, emits its result, and returns to idle in the same cycle that the result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| abort | input | 1 | Return to idle |
| next_slice | input | 1 | Begin the next slice while waiting |
| cal_mode | input | 1 | Makes a start into a calibration run |
| thr_start | input | THR_W | First threshold code |
| thr_stop | input | THR_W | Highest code allowed |
| thr_step | input | THR_W | Code increment |
| trial_target | input | CNT_W | Trials per point (0 counts as 1) |
| sample_strobe | input | 1 | Comparator decision is valid |
| comp_bit | input | 1 | Comparator decision |
| thr_code | output | THR_W | Threshold code driven to the DAC |
| slice_idx | output | SLICE_W | Current time-slice number |
| busy | output | 1 | A run is in progress (includes waiting) |
| slice_done | output | 1 | Slice walk finished; waiting for next_slice |
| cal_sel | output | 1 | Comparator routed to the calibration reference |
| result_valid | output | 1 | One-cycle result strobe |
| res_thr | output | THR_W | Code of the finished point |
| res_slice | output | SLICE_W | Slice of the finished point |
| res_hits | output | CNT_W | High decisions in the point |
| res_trials | output | CNT_W | Trials in the point |

## Verification
The assertions check several properties on every cycle:
- the hit count never exceeds the trial count;
- the counters stay frozen when there is neither a strobe nor a clear;
- every result carries exactly the target trial count, with the counters cleared behind it;
- abort always leads to idle;
- the waiting state persists until a next-slice command arrives;
- a start during a run leaves the slice number unchanged;
- a calibration result always ends the run.

Only the bench scenarios can show that each emitted hit count matches the comparator pattern that was actually driven. They also show the order of codes across a window, including windows whose step would overflow the code width or is zero. Finally, they show that strobes are dropped while waiting and that a run after an abort begins from zero.

// File: rtl/cdf_sweep_pkg.sv
package cdf_sweep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CAL  = 2'd2,
        ST_WAIT = 2'd3
    } sweep_state_t;
endpackage

// File: rtl/cdf_thr_next.sv
// Computes the following threshold code and flags the last point of a window.
module cdf_thr_next #(
    parameter int THR_W = 8
) (
    input  logic [THR_W-1:0] code,
    input  logic [THR_W-1:0] step,
    input  logic [THR_W-1:0] stop,
    output logic [THR_W-1:0] next_code,
    output logic             last_pt
);
    logic [THR_W:0] sum_wide;

    always_comb begin
        // One extra bit so that an overflowing step ends the window instead of wrapping.
        sum_wide  = {1'b0, code} + {1'b0, step};
        next_code = sum_wide[THR_W-1:0];
        last_pt   = (step == '0) || (sum_wide > {1'b0, stop});
    end
endmodule

// File: rtl/cdf_count_pair.sv
// Trial and hit tallies for one threshold point.
module cdf_count_pair #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             bit_in,
    output logic [CNT_W-1:0] trials_q,
    output logic [CNT_W-1:0] hits_q,
    output logic [CNT_W-1:0] trials_nx,
    output logic [CNT_W-1:0] hits_nx
);
    typedef struct packed {
        logic [CNT_W-1:0] trials;
        logic [CNT_W-1:0] hits;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        trials_nx = cnt_q.trials + 1'b1;
        hits_nx   = cnt_q.hits + {{(CNT_W-1){1'b0}}, bit_in};
        cnt_d     = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d.trials = trials_nx;
            cnt_d.hits   = hits_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trials_q = cnt_q.trials;
    assign hits_q   = cnt_q.hits;

    p_hits_le_trials_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hits_q <= trials_q);

    p_hold_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> ($stable(trials_q) && $stable(hits_q)));
endmodule

// File: rtl/cdf_sweep_accum.sv
module cdf_sweep_accum
    import cdf_sweep_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int THR_W   = 8,
    parameter int SLICE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic               next_slice,
    input  logic               cal_mode,
    input  logic [THR_W-1:0]   thr_start,
    input  logic [THR_W-1:0]   thr_stop,
    input  logic [THR_W-1:0]   thr_step,
    input  logic [CNT_W-1:0]   trial_target,
    input  logic               sample_strobe,
    input  logic               comp_bit,
    output logic [THR_W-1:0]   thr_code,
    output logic [SLICE_W-1:0] slice_idx,
    output logic               busy,
    output logic               slice_done,
    output logic               cal_sel,
    output logic               result_valid,
    output logic [THR_W-1:0]   res_thr,
    output logic [SLICE_W-1:0] res_slice,
    output logic [CNT_W-1:0]   res_hits,
    output logic [CNT_W-1:0]   res_trials
);
    localparam logic [CNT_W-1:0] ONE_TRIAL = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        sweep_state_t       st;
        logic [THR_W-1:0]   c_start;
        logic [THR_W-1:0]   c_stop;
        logic [THR_W-1:0]   c_step;
        logic [CNT_W-1:0]   c_target;
        logic [THR_W-1:0]   code;
        logic [SLICE_W-1:0] slice;
        logic               valid;
        logic [THR_W-1:0]   r_thr;
        logic [SLICE_W-1:0] r_slice;
        logic [CNT_W-1:0]   r_hits;
        logic [CNT_W-1:0]   r_trials;
    } regs_t;

    regs_t r_d, r_q;

    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] trials_q, hits_q, trials_nx, hits_nx;
    logic [THR_W-1:0] code_nx;
    logic             code_last;

    cdf_count_pair #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .bit_in    (comp_bit),
        .trials_q  (trials_q),
        .hits_q    (hits_q),
        .trials_nx (trials_nx),
        .hits_nx   (hits_nx)
    );

    cdf_thr_next #(.THR_W(THR_W)) u_step (
        .code      (r_q.code),
        .step      (r_q.c_step),
        .stop      (r_q.c_stop),
        .next_code (code_nx),
        .last_pt   (code_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.valid = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = cal_mode ? ST_CAL : ST_RUN;
                    r_d.c_start  = thr_start;
                    r_d.c_stop   = thr_stop;
                    r_d.c_step   = thr_step;
                    r_d.c_target = (trial_target == '0) ? ONE_TRIAL : trial_target;
                    r_d.code     = thr_start;
                    r_d.slice    = '0;
                    cnt_clr      = 1'b1;
                end
            end
            ST_RUN, ST_CAL: begin
                if (sample_strobe) begin
                    if (trials_nx == r_q.c_target) begin
                        // Point finished: publish the final tallies and restart the counters.
                        r_d.valid    = 1'b1;
                        r_d.r_thr    = r_q.code;
                        r_d.r_slice  = r_q.slice;
                        r_d.r_hits   = hits_nx;
                        r_d.r_trials = trials_nx;
                        cnt_clr      = 1'b1;
                        if (r_q.st == ST_CAL) r_d.st = ST_IDLE;
                        else if (code_last)   r_d.st = ST_WAIT;
                        else                  r_d.code = code_nx;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (next_slice) begin
                    r_d.st    = ST_RUN;
                    r_d.slice = r_q.slice + 1'b1;
                    r_d.code  = r_q.c_start;
                    cnt_clr   = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (abort) begin
            r_d.st    = ST_IDLE;
            r_d.valid = 1'b0;
            cnt_clr   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign thr_code     = r_q.code;
    assign slice_idx    = r_q.slice;
    assign busy         = (r_q.st != ST_IDLE);
    assign slice_done   = (r_q.st == ST_WAIT);
    assign cal_sel      = (r_q.st == ST_CAL);
    assign result_valid = r_q.valid;
    assign res_thr      = r_q.r_thr;
    assign res_slice    = r_q.r_slice;
    assign res_hits     = r_q.r_hits;
    assign res_trials   = r_q.r_trials;

    p_result_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (res_trials == r_q.c_target && res_hits <= res_trials));

    p_clear_after_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (trials_q == '0 && hits_q == '0));

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_done && !next_slice && !abort) |=> slice_done);

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !next_slice && !abort) |=> (slice_idx == $past(slice_idx)));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !result_valid));

    p_cal_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_sel && sample_strobe && trials_nx == r_q.c_target && !abort) |=> (result_valid && !busy));
endmodule

// File: tb/cdf_sweep_accum_test.sv
`timescale 1ns/1ps
module cdf_sweep_accum_test;
    localparam int CW = 20;
    localparam int TW = 8;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, abort = 0, next_slice = 0, cal_mode = 0;
    logic [TW-1:0] thr_start = 0, thr_stop = 0, thr_step = 0;
    logic [CW-1:0] trial_target = 0;
    logic sample_strobe = 0, comp_bit = 0;
    logic [TW-1:0] thr_code, res_thr;
    logic [SW-1:0] slice_idx, res_slice;
    logic busy, slice_done, cal_sel, result_valid;
    logic [CW-1:0] res_hits, res_trials;

    always #2 clk = ~clk;

    cdf_sweep_accum #(.CNT_W(CW), .THR_W(TW), .SLICE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .next_slice(next_slice), .cal_mode(cal_mode),
        .thr_start(thr_start), .thr_stop(thr_stop), .thr_step(thr_step),
        .trial_target(trial_target), .sample_strobe(sample_strobe),
        .comp_bit(comp_bit), .thr_code(thr_code), .slice_idx(slice_idx),
        .busy(busy), .slice_done(slice_done), .cal_sel(cal_sel),
        .result_valid(result_valid), .res_thr(res_thr), .res_slice(res_slice),
        .res_hits(res_hits), .res_trials(res_trials)
    );

    typedef struct {
        logic [TW-1:0] thr;
        logic [SW-1:0] sl;
        logic [CW-1:0] hits;
        logic [CW-1:0] trials;
        string         req;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && result_valid && !finished) begin
            if (sb.size() == 0) begin
                chk(0, "R4 unexpected result", res_thr, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(res_thr == e.thr && res_slice == e.sl && res_hits == e.hits
                    && res_trials == e.trials, e.req,
                    {res_thr, res_slice, res_hits}, {e.thr, e.sl, e.hits});
            end
        end
    end

    task automatic do_point(input int n, input logic [31:0] pat,
                            input logic [TW-1:0] thr, input logic [SW-1:0] sl,
                            input bit gaps, input string req);
        exp_t e;
        int h = 0;
        for (int i = 0; i < n; i++) h += pat[i];
        e.thr = thr; e.sl = sl; e.hits = h; e.trials = n; e.req = req;
        sb.push_back(e);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sample_strobe = 1; comp_bit = pat[i];
            if (gaps && i != n - 1) begin
                @(negedge clk); sample_strobe = 0; comp_bit = 1;
            end
        end
        @(negedge clk); sample_strobe = 0; comp_bit = 0;
    endtask

    task automatic go(input logic [TW-1:0] a, input logic [TW-1:0] b,
                      input logic [TW-1:0] s, input logic [CW-1:0] t, input bit cal);
        @(negedge clk);
        thr_start = a; thr_stop = b; thr_step = s; trial_target = t; cal_mode = cal;
        start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1 && thr_code == a && slice_idx == 0, "R2 start latch", thr_code, a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !slice_done && !result_valid && !cal_sel, "R1 reset state",
            {busy, slice_done, result_valid, cal_sel}, 0);

        // Window 10..20 step 5, four trials per point.
        go(8'd10, 8'd20, 8'd5, 20'd4, 0);
        chk(cal_sel == 0, "R9 no cal_sel in sweep", cal_sel, 0);
        do_point(4, 32'b1011, 8'd10, 0, 1, "R3 gapped strobes slice0 code10");
        chk(thr_code == 15, "R5 code advance", thr_code, 15);
        do_point(4, 32'b0000, 8'd15, 0, 0, "R3 all low code15");
        do_point(4, 32'b1111, 8'd20, 0, 0, "R5 last code20");
        chk(slice_done == 1 && busy == 1, "R5 slice_done raised", slice_done, 1);
        // Strobes while waiting: no result must appear.
        repeat (6) begin @(negedge clk); sample_strobe = 1; comp_bit = 1; end
        @(negedge clk); sample_strobe = 0; comp_bit = 0;
        chk(slice_done == 1 && sb.size() == 0, "R5 strobes ignored in wait", sb.size(), 0);
        // Start while waiting is ignored.
        @(negedge clk); start = 1; thr_start = 8'd99;
        @(negedge clk); start = 0;
        chk(slice_done == 1 && slice_idx == 0, "R7 start ignored in wait", slice_idx, 0);
        @(negedge clk); next_slice = 1;
        @(negedge clk); next_slice = 0;
        chk(slice_idx == 1 && thr_code == 10 && !slice_done, "R6 next slice", thr_code, 10);
        do_point(4, 32'b0110, 8'd10, 1, 0, "R6 slice1 code10");
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(thr_code == 15 && slice_idx == 1 && busy, "R7 start ignored in run", thr_code, 15);
        do_point(4, 32'b0001, 8'd15, 1, 1, "R7 counts continue");
        // Abort mid-point.
        @(negedge clk); sample_strobe = 1; comp_bit = 1;
        @(negedge clk); sample_strobe = 1; comp_bit = 1;
        @(negedge clk); sample_strobe = 0; abort = 1;
        @(negedge clk); abort = 0;
        chk(!busy && !slice_done && sb.size() == 0, "R8 abort to idle", busy, 0);
        // Fresh run after abort counts from zero; target 0 behaves as 1.
        go(8'd3, 8'd5, 8'd1, 20'd0, 0);
        do_point(1, 32'b1, 8'd3, 0, 0, "R4 target0 as 1 code3");
        do_point(1, 32'b0, 8'd4, 0, 0, "R4 target0 as 1 code4");
        do_point(1, 32'b1, 8'd5, 0, 0, "R4 target0 as 1 code5");
        chk(slice_done == 1, "R5 done after code5", slice_done, 1);
        @(negedge clk); abort = 1;
        @(negedge clk); abort = 0;
        chk(!busy, "R8 abort from wait", busy, 0);
        // Step overflowing the code width ends after one point.
        go(8'd250, 8'd255, 8'd10, 20'd6, 0);
        do_point(6, 32'b101010, 8'd250, 0, 0, "R5 overflow step single point");
        chk(slice_done == 1, "R5 overflow ends window", slice_done, 1);
        @(negedge clk); abort = 1;
        @(negedge clk); abort = 0;
        // Zero step ends after one point.
        go(8'd7, 8'd200, 8'd0, 20'd3, 0);
        do_point(3, 32'b011, 8'd7, 0, 0, "R5 zero step single point");
        chk(slice_done == 1 && thr_code == 7, "R5 zero step ends", thr_code, 7);
        @(negedge clk); abort = 1;
        @(negedge clk); abort = 0;
        // Calibration run.
        go(8'd33, 8'd40, 8'd1, 20'd5, 1);
        chk(cal_sel == 1, "R9 cal_sel high", cal_sel, 1);
        do_point(5, 32'b11001, 8'd33, 0, 1, "R9 cal point");
        chk(!busy && !slice_done && !cal_sel, "R9 cal returns idle", busy, 0);
        // Longer point with 20 trials.
        go(8'd0, 8'd0, 8'd1, 20'd20, 0);
        do_point(20, 32'hA5F3C, 8'd0, 0, 0, "R3 twenty trials");
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R4 all results seen", sb.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule